// File: doc/BRIEF.md
# Error-Correcting SRAM Access Controller

This block sits between a 32-bit requester and a word-wide synchronous memory array. Each word is stored with 7 check bits of a single-error-correct, double-error-detect code. A request is taken with a valid/ready handshake. The access is stretched by a programmable number of wait cycles, and the count used depends on whether the requester is in the slow class or the fast class. Reads are decoded. A correctable error is repaired in the returned data and can also be repaired in the array by an automatic write-back. An uncorrectable error is flagged, and the raw word is returned.

Writes that cover fewer than four bytes are done as read-modify-write, so the check bits always cover the whole word. For test, a full-word write to one programmed word address can store a check-bit value supplied by software instead of the computed one. Three configuration registers are reached through a simple select/write port with combinational readback. Error events leave the block as one-cycle pulses, together with the failing word address.

Top module: `ecc_sram_ctrl`

## Requirements
- R1: Out of reset, the control register (select 0) reads 0x00030001, and the injection address register (select 1) and the injection parity register (select 2) read 0. In the control register, the slow wait count sits in bits 1:0 and the fast wait count in bits 9:8. Check enable is bit 16, auto-correct enable is bit 17 and injection enable is bit 18. All other bits read zero. Writing all ones reads back 0x00070303, 0x3F and 0x7F.
- R2: `req_ready` is high only when the controller is idle. It stays low from the accepting edge until the response cycle. `rsp_valid` lasts exactly one cycle.
- R3: With N the wait count of the requester's class, a full-word write responds N+1 cycles after the accepting edge. Reads and partial writes respond N+2 cycles after it.
- R4: Read data returns what was written. A partial write replaces only the bytes whose `req_be` bit is set (bit b covers data bits 8b+7:8b).
- R5: The all-zero data word has all-zero check bits. A stored word at distance one from a valid codeword (one data or check bit wrong) is read back corrected, with a one-cycle `err_corr` pulse on the response cycle and `err_addr` equal to the word address.
- R6: A stored word with two wrong bits gives an `err_uncorr` pulse, returns the raw stored data and causes no array write.
- R7: With check enable at 0, read data is returned raw and neither error pulse fires.
- R8: With auto-correct on, a read that finds a correctable error is followed by one write-back cycle (ready still low), and a later read of that word is clean. With auto-correct off, no write-back happens and the error is seen again.
- R9: With injection on, a full-word write to the injection address stores the injection parity register as check bits. Writes to other addresses, or any write with injection off, store computed check bits.
- R10: A partial write to the injection address stores computed check bits even with injection on.
- R11: The read phase of a partial write is decoded. A correctable error there gives an `err_corr` pulse, and the merge uses the corrected bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_slow | input | 1 | Requester class: 1 = slow, 0 = fast |
| req_addr | input | ADDR_W | Word address |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid on reads |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | 0 control, 1 injection address, 2 injection parity |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register contents |
| err_corr | output | 1 | Correctable error pulse |
| err_uncorr | output | 1 | Uncorrectable error pulse |
| err_addr | output | ADDR_W | Word address of the reported error |

## Verification
A full-word write answers N+1 cycles after the accepting edge, and a read or partial write answers N+2 cycles after it. The error pulses and `err_addr` share the response cycle, and a write-back shows as `req_ready` still low one cycle after the response. Each access task counts falling edges from the accepting edge until `rsp_valid` is seen. It compares that count with the expected latency and captures data and error flags in that same half-cycle. It then samples `req_ready` one falling edge later to tell write-back from idle. Errors are made only through the injection path, which relies on the zero-word code property stated in R5.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;

  localparam int DATA_W    = 32;
  localparam int HAM_W     = 6;
  localparam int CHK_W     = HAM_W + 1;
  localparam int CODE_LAST = DATA_W + HAM_W;
  localparam int WS_W      = 2;

  typedef struct packed {
    logic            inj_en;
    logic            auto_fix;
    logic            chk_en;
    logic [WS_W-1:0] fast_ws;
    logic [WS_W-1:0] slow_ws;
  } ctrl_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              corr;
    logic              uncorr;
  } dec_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_MEM,
    ST_CHK,
    ST_WB
  } seq_state_e;

  // XOR of the code positions of all set data bits; data takes every
  // non-power-of-two position from 3 up to CODE_LAST.
  function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    int k;
    h = '0;
    k = 0;
    for (int p = 1; p <= CODE_LAST; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[k[4:0]]) h = h ^ p[HAM_W-1:0];
        k++;
      end
    end
    return h;
  endfunction

  function automatic logic [CHK_W-1:0] secded_encode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = ham_bits(d);
    return {(^d) ^ (^h), h};
  endfunction

  function automatic dec_t secded_decode(input logic [DATA_W-1:0] d,
                                         input logic [CHK_W-1:0]  c);
    dec_t r;
    logic [HAM_W-1:0] syn;
    logic odd;
    int k;
    syn      = ham_bits(d) ^ c[HAM_W-1:0];
    odd      = (^d) ^ (^c);
    r.data   = d;
    r.corr   = 1'b0;
    r.uncorr = 1'b0;
    if (odd) begin
      if (int'(syn) > CODE_LAST) begin
        r.uncorr = 1'b1;
      end else begin
        r.corr = 1'b1;
        k = 0;
        for (int p = 1; p <= CODE_LAST; p++) begin
          if ((p & (p - 1)) != 0) begin
            if (p == int'(syn)) r.data[k[4:0]] = ~d[k[4:0]];
            k++;
          end
        end
      end
    end else if (syn != '0) begin
      r.uncorr = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/ecc_sram_cfg.sv
module ecc_sram_cfg
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  output ctrl_t                ctrl_o,
  output logic [ADDR_W-1:0]    inj_addr_o,
  output logic [CHK_W-1:0]     inj_par_o
);

  localparam ctrl_t CTRL_RST = '{inj_en: 1'b0, auto_fix: 1'b1, chk_en: 1'b1,
                                 fast_ws: '0, slow_ws: WS_W'(1)};

  ctrl_t             ctrl_q, ctrl_d;
  logic [ADDR_W-1:0] inj_addr_q, inj_addr_d;
  logic [CHK_W-1:0]  inj_par_q, inj_par_d;

  always_comb begin
    ctrl_d     = ctrl_q;
    inj_addr_d = inj_addr_q;
    inj_par_d  = inj_par_q;
    if (cfg_we) begin
      unique case (cfg_sel)
        2'd0: ctrl_d = '{inj_en:   cfg_wdata[18],
                         auto_fix: cfg_wdata[17],
                         chk_en:   cfg_wdata[16],
                         fast_ws:  cfg_wdata[8 +: WS_W],
                         slow_ws:  cfg_wdata[0 +: WS_W]};
        2'd1: inj_addr_d = cfg_wdata[ADDR_W-1:0];
        2'd2: inj_par_d  = cfg_wdata[CHK_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= CTRL_RST;
      inj_addr_q <= '0;
      inj_par_q  <= '0;
    end else begin
      ctrl_q     <= ctrl_d;
      inj_addr_q <= inj_addr_d;
      inj_par_q  <= inj_par_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_sel)
      2'd0: begin
        cfg_rdata[18]           = ctrl_q.inj_en;
        cfg_rdata[17]           = ctrl_q.auto_fix;
        cfg_rdata[16]           = ctrl_q.chk_en;
        cfg_rdata[8 +: WS_W]    = ctrl_q.fast_ws;
        cfg_rdata[0 +: WS_W]    = ctrl_q.slow_ws;
      end
      2'd1: cfg_rdata[ADDR_W-1:0] = inj_addr_q;
      2'd2: cfg_rdata[CHK_W-1:0]  = inj_par_q;
      default: ;
    endcase
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_wdata[31:19], cfg_wdata[15:10], cfg_wdata[7:2]};

  assign ctrl_o     = ctrl_q;
  assign inj_addr_o = inj_addr_q;
  assign inj_par_o  = inj_par_q;

  AST_INJ_PAR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(inj_par_q)); // R9

endmodule

// File: rtl/ecc_sram_mem.sv
module ecc_sram_mem #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 39
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] arr [DEPTH];
  logic [WORD_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) arr[addr] <= wdata;
    if (re) rdata_q   <= arr[addr];
  end

  assign rdata = rdata_q;

  AST_NO_RW_SAME_CYCLE: assert property (@(posedge clk) !(we && re)); // R4

endmodule

// File: rtl/ecc_sram_dec.sv
module ecc_sram_dec
  import ecc_sram_pkg::*;
(
  input  logic [DATA_W+CHK_W-1:0] word,
  input  logic                    chk_en,
  output logic [DATA_W-1:0]       data,
  output logic                    corr,
  output logic                    uncorr
);

  dec_t r;

  always_comb begin
    r      = secded_decode(word[DATA_W-1:0], word[DATA_W +: CHK_W]);
    data   = chk_en ? r.data : word[DATA_W-1:0];
    corr   = chk_en & r.corr;
    uncorr = chk_en & r.uncorr;
  end

endmodule

// File: rtl/ecc_sram_ctrl.sv
module ecc_sram_ctrl
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_slow,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              err_corr,
  output logic              err_uncorr,
  output logic [ADDR_W-1:0] err_addr
);

  localparam int WORD_W = DATA_W + CHK_W;
  localparam int BE_W   = DATA_W / 8;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  ctrl_t             ctrl;
  logic [ADDR_W-1:0] inj_addr;
  logic [CHK_W-1:0]  inj_par;

  ecc_sram_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(srst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ctrl_o(ctrl),
    .inj_addr_o(inj_addr), .inj_par_o(inj_par)
  );

  seq_state_e        state_q, state_d;
  logic [WS_W-1:0]   cnt_q, cnt_d;
  logic              q_write;
  logic [ADDR_W-1:0] q_addr;
  logic [BE_W-1:0]   q_be;
  logic [DATA_W-1:0] q_wdata;
  logic              accept;

  logic              mem_we, mem_re;
  logic [WORD_W-1:0] mem_wdata, mem_rdata;

  ecc_sram_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk(clk), .we(mem_we), .re(mem_re), .addr(q_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

  logic [DATA_W-1:0] eff_data, merged;
  logic              dec_corr, dec_uncorr;

  ecc_sram_dec u_dec (
    .word(mem_rdata), .chk_en(ctrl.chk_en),
    .data(eff_data), .corr(dec_corr), .uncorr(dec_uncorr)
  );

  for (genvar b = 0; b < BE_W; b++) begin : g_merge
    assign merged[8*b +: 8] = q_be[b] ? q_wdata[8*b +: 8] : eff_data[8*b +: 8];
  end

  logic full_word, inj_hit;
  assign full_word = &q_be;
  assign inj_hit   = ctrl.inj_en && (q_addr == inj_addr);
  assign accept    = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = '0;
    rsp_valid = 1'b0;
    rsp_rdata = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cnt_d   = req_slow ? ctrl.slow_ws : ctrl.fast_ws;
          state_d = (cnt_d == '0) ? ST_MEM : ST_WAIT;
        end
      end
      ST_WAIT: begin
        cnt_d = cnt_q - WS_W'(1);
        if (cnt_q == WS_W'(1)) state_d = ST_MEM;
      end
      ST_MEM: begin
        if (q_write && full_word) begin
          mem_we    = 1'b1;
          mem_wdata = {inj_hit ? inj_par : secded_encode(q_wdata), q_wdata};
          rsp_valid = 1'b1;
          state_d   = ST_IDLE;
        end else begin
          mem_re  = 1'b1;
          state_d = ST_CHK;
        end
      end
      ST_CHK: begin
        rsp_valid = 1'b1;
        state_d   = ST_IDLE;
        if (q_write) begin
          mem_we    = 1'b1;
          mem_wdata = {secded_encode(merged), merged};
        end else begin
          rsp_rdata = eff_data;
          if (dec_corr && ctrl.auto_fix) state_d = ST_WB;
        end
      end
      ST_WB: begin
        mem_we    = 1'b1;
        mem_wdata = {secded_encode(eff_data), eff_data};
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      q_write <= 1'b0;
      q_addr  <= '0;
      q_be    <= '0;
      q_wdata <= '0;
    end else if (accept) begin
      q_write <= req_write;
      q_addr  <= req_addr;
      q_be    <= req_be;
      q_wdata <= req_wdata;
    end
  end

  assign req_ready  = (state_q == ST_IDLE) && srst_n;
  assign err_corr   = (state_q == ST_CHK) && dec_corr;
  assign err_uncorr = (state_q == ST_CHK) && dec_uncorr;
  assign err_addr   = q_addr;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!srst_n)
    rsp_valid |=> !rsp_valid); // R2
  AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (!srst_n)
    (err_corr || err_uncorr) |-> rsp_valid); // R5
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!srst_n)
    !(err_corr && err_uncorr)); // R6
  AST_UNCORR_NO_WB: assert property (@(posedge clk) disable iff (!srst_n)
    err_uncorr |=> !mem_we); // R6
  AST_NO_ERR_UNCHECKED: assert property (@(posedge clk) disable iff (!srst_n)
    !ctrl.chk_en |-> !(err_corr || err_uncorr)); // R7
  AST_WB_FOLLOWS_FIX: assert property (@(posedge clk) disable iff (!srst_n)
    (err_corr && !q_write && ctrl.auto_fix) |=> (mem_we && !req_ready)); // R8

endmodule

// File: tb/ecc_sram_ctrl_bench.sv
module ecc_sram_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_slow;
  logic        req_ready;
  logic [5:0]  req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        err_corr, err_uncorr;
  logic [5:0]  err_addr;

  int checks = 0;
  int errors = 0;

  logic [31:0] r_data;
  logic        r_corr, r_unc, r_busy_ok, r_rdy_after;
  logic [5:0]  r_eaddr;
  int          r_lat;

  always #5 clk = ~clk;

  ecc_sram_ctrl u_ecc_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_slow(req_slow), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .err_corr(err_corr),
    .err_uncorr(err_uncorr), .err_addr(err_addr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [1:0] sel, output logic [31:0] val);
    @(negedge clk);
    cfg_sel = sel;
    #1 val = cfg_rdata;
  endtask

  task automatic set_ctrl(input int slow, input int fast, input bit chk, input bit fix, input bit inj);
    cfg_wr(2'd0, {13'd0, inj, fix, chk, 6'd0, 2'(fast), 6'd0, 2'(slow)});
  endtask

  task automatic access(input logic wr, input logic slow, input logic [5:0] addr,
                        input logic [31:0] wd, input logic [3:0] be);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_slow = slow;
    req_addr = addr; req_wdata = wd; req_be = be;
    @(posedge clk);
    r_lat = 0; r_busy_ok = 1'b1;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      r_lat++;
      if (!rsp_valid && req_ready) r_busy_ok = 1'b0;
    end while (!rsp_valid && r_lat < 20);
    r_data = rsp_rdata; r_corr = err_corr; r_unc = err_uncorr; r_eaddr = err_addr;
    @(negedge clk);
    r_rdy_after = req_ready;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R2 ready after reset", 32'(req_ready), 32'd1);
    check("R2 no rsp after reset", 32'(rsp_valid), 32'd0);
    cfg_rd(2'd0, v); check("R1 ctrl reset", v, 32'h0003_0001);
    cfg_rd(2'd1, v); check("R1 inj addr reset", v, 32'd0);
    cfg_rd(2'd2, v); check("R1 inj parity reset", v, 32'd0);
    cfg_wr(2'd0, 32'hFFFF_FFFF); cfg_rd(2'd0, v); check("R1 ctrl ones", v, 32'h0007_0303);
    cfg_wr(2'd1, 32'hFFFF_FFFF); cfg_rd(2'd1, v); check("R1 addr ones", v, 32'h0000_003F);
    cfg_wr(2'd2, 32'hFFFF_FFFF); cfg_rd(2'd2, v); check("R1 parity ones", v, 32'h0000_007F);
    cfg_wr(2'd0, 32'h0003_0001); cfg_wr(2'd1, 32'd0); cfg_wr(2'd2, 32'd0);
  endtask

  task automatic t_latency;
    access(1'b1, 1'b1, 6'd1, 32'hDEAD_BEEF, 4'hF);
    check("R3 slow full write lat", 32'(r_lat), 32'd2);
    check("R2 ready low while busy", 32'(r_busy_ok), 32'd1);
    access(1'b0, 1'b1, 6'd1, 32'd0, 4'h0);
    check("R3 slow read lat", 32'(r_lat), 32'd3);
    check("R4 read data", r_data, 32'hDEAD_BEEF);
    access(1'b0, 1'b0, 6'd1, 32'd0, 4'h0);
    check("R3 fast read lat", 32'(r_lat), 32'd2);
    set_ctrl(3, 2, 1, 1, 0);
    access(1'b0, 1'b1, 6'd1, 32'd0, 4'h0);
    check("R3 slow ws3 read lat", 32'(r_lat), 32'd5);
    check("R2 ready low in wait states", 32'(r_busy_ok), 32'd1);
    access(1'b1, 1'b0, 6'd1, 32'h0000_0011, 4'h1);
    check("R3 fast ws2 partial lat", 32'(r_lat), 32'd4);
    access(1'b1, 1'b0, 6'd2, 32'h5555_AAAA, 4'hF);
    check("R3 fast ws2 full lat", 32'(r_lat), 32'd3);
    set_ctrl(1, 0, 1, 1, 0);
  endtask

  task automatic t_data;
    access(1'b1, 1'b0, 6'd63, 32'h1234_5678, 4'hF);
    access(1'b0, 1'b0, 6'd63, 32'd0, 4'h0);
    check("R4 roundtrip top addr", r_data, 32'h1234_5678);
    check("R5 clean read no corr", 32'(r_corr), 32'd0);
    access(1'b1, 1'b0, 6'd7, 32'h1122_3344, 4'hF);
    access(1'b1, 1'b0, 6'd7, 32'h0000_AB00, 4'b0010);
    access(1'b0, 1'b0, 6'd7, 32'd0, 4'h0);
    check("R4 partial byte1", r_data, 32'h1122_AB44);
    access(1'b1, 1'b0, 6'd7, 32'hCAFE_0000, 4'b1100);
    access(1'b0, 1'b0, 6'd7, 32'd0, 4'h0);
    check("R4 partial upper half", r_data, 32'hCAFE_AB44);
  endtask

  task automatic t_correct;
    cfg_wr(2'd1, 32'd10); cfg_wr(2'd2, 32'd0);
    set_ctrl(1, 0, 1, 0, 1);
    access(1'b1, 1'b0, 6'd10, 32'h0000_0010, 4'hF);
    access(1'b0, 1'b0, 6'd10, 32'd0, 4'h0);
    check("R5 data bit corrected", r_data, 32'd0);
    check("R5 corr pulse", 32'(r_corr), 32'd1);
    check("R5 err addr", 32'(r_eaddr), 32'd10);
    check("R8 no wb when off", 32'(r_rdy_after), 32'd1);
    access(1'b0, 1'b0, 6'd10, 32'd0, 4'h0);
    check("R8 error persists without wb", 32'(r_corr), 32'd1);
    set_ctrl(1, 0, 1, 1, 1);
    access(1'b0, 1'b0, 6'd10, 32'd0, 4'h0);
    check("R8 corr with wb", 32'(r_corr), 32'd1);
    check("R8 wb keeps ready low", 32'(r_rdy_after), 32'd0);
    access(1'b0, 1'b0, 6'd10, 32'd0, 4'h0);
    check("R8 repaired no corr", 32'(r_corr), 32'd0);
    check("R8 repaired data", r_data, 32'd0);
    cfg_wr(2'd2, 32'd1);
    access(1'b1, 1'b0, 6'd10, 32'd0, 4'hF);
    access(1'b0, 1'b0, 6'd10, 32'd0, 4'h0);
    check("R5 check bit error corr", 32'(r_corr), 32'd1);
    check("R5 check bit error data", r_data, 32'd0);
  endtask

  task automatic t_double;
    cfg_wr(2'd2, 32'd0);
    set_ctrl(1, 0, 1, 1, 1);
    access(1'b1, 1'b0, 6'd10, 32'h0000_0003, 4'hF);
    access(1'b0, 1'b0, 6'd10, 32'd0, 4'h0);
    check("R6 uncorr pulse", 32'(r_unc), 32'd1);
    check("R6 no corr pulse", 32'(r_corr), 32'd0);
    check("R6 raw data", r_data, 32'h0000_0003);
    check("R6 no wb", 32'(r_rdy_after), 32'd1);
    access(1'b0, 1'b0, 6'd10, 32'd0, 4'h0);
    check("R6 still uncorr", 32'(r_unc), 32'd1);
  endtask

  task automatic t_unchecked;
    set_ctrl(1, 0, 1, 1, 1);
    access(1'b1, 1'b0, 6'd10, 32'h0000_0010, 4'hF);
    set_ctrl(1, 0, 0, 1, 0);
    access(1'b0, 1'b0, 6'd10, 32'd0, 4'h0);
    check("R7 raw when off", r_data, 32'h0000_0010);
    check("R7 no corr when off", 32'(r_corr), 32'd0);
    check("R7 no uncorr when off", 32'(r_unc), 32'd0);
  endtask

  task automatic t_inject_scope;
    set_ctrl(1, 0, 1, 1, 1);
    access(1'b1, 1'b0, 6'd11, 32'h0000_0010, 4'hF);
    access(1'b0, 1'b0, 6'd11, 32'd0, 4'h0);
    check("R9 other addr clean", 32'(r_corr), 32'd0);
    check("R9 other addr data", r_data, 32'h0000_0010);
    set_ctrl(1, 0, 1, 1, 0);
    access(1'b1, 1'b0, 6'd10, 32'h0000_0010, 4'hF);
    access(1'b0, 1'b0, 6'd10, 32'd0, 4'h0);
    check("R9 inj off clean", 32'(r_corr), 32'd0);
    set_ctrl(1, 0, 1, 1, 1);
    access(1'b1, 1'b0, 6'd10, 32'h0000_0000, 4'b0001);
    access(1'b1, 1'b0, 6'd10, 32'h0000_0010, 4'b0001);
    access(1'b0, 1'b0, 6'd10, 32'd0, 4'h0);
    check("R10 partial uses computed", 32'(r_corr), 32'd0);
    check("R10 partial data", r_data, 32'h0000_0010);
  endtask

  task automatic t_rmw;
    cfg_wr(2'd1, 32'd12); cfg_wr(2'd2, 32'd0);
    set_ctrl(1, 0, 1, 1, 1);
    access(1'b1, 1'b0, 6'd12, 32'h0000_0010, 4'hF);
    set_ctrl(1, 0, 1, 1, 0);
    access(1'b1, 1'b0, 6'd12, 32'h0077_0000, 4'b0100);
    check("R11 rmw corr pulse", 32'(r_corr), 32'd1);
    check("R11 rmw err addr", 32'(r_eaddr), 32'd12);
    access(1'b0, 1'b0, 6'd12, 32'd0, 4'h0);
    check("R11 merged corrected", r_data, 32'h0077_0000);
    check("R11 stored clean", 32'(r_corr), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_slow = 1'b0;
    req_addr = '0; req_be = '0; req_wdata = '0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_latency;
    t_data;
    t_correct;
    t_double;
    t_unchecked;
    t_inject_scope;
    t_rmw;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule